// File: doc/BRIEF.md
# Serial Port Request Steering and Arbitration

This block sits between the event flags of a serial port and the interrupt and DMA fabric of the chip. The port raises a receive-data-pending flag and two transmit flags: the buffer is empty, and the shift register is empty. Each direction has a DMA mask bit. When the mask is set, the direction's flags become a DMA request. When it is clear, they become an interrupt request. The masks are loaded by software. Each mask is cleared by hardware when the DMA transaction counter for its direction reaches zero. If the mask was set at that moment, a sticky end-of-block flag is raised for that direction.

All pending requests are resolved every clock in a fixed internal order: receive DMA, then transmit DMA, then receive interrupt, then transmit interrupt. The block registers a single winner and tags it with the port's 3-bit priority level. Level 7 means the port has no priority, and nothing is presented. When a presented request is acknowledged, that direction's flag requests are held off until the flag drops. The block then re-arms for the next event.

Top module: `sci_req_ctrl`

## Requirements
- R1: With the receive mask at 1, a high `rx_data_pend` yields kind 0 (receive DMA). With the mask at 0, it yields kind 2 (receive interrupt).
- R2: With the transmit mask at 1, either `tx_buf_empty` or `tx_shift_empty` yields kind 1 (transmit DMA). With the mask at 0, either flag yields kind 3 (transmit interrupt).
- R3: When several requests are pending, the presented kind is the lowest code among them. The order is 0 (receive DMA), 1 (transmit DMA), 2 (receive interrupt), 3 (transmit interrupt).
- R4: `req_level` carries the `prio_lvl` value of the previous cycle. When that value is 7, `req_valid` is 0.
- R5: A cycle with `mask_we` high loads `rx_mask_wdata`/`tx_mask_wdata` into the masks. A counter-zero pulse clears its direction's mask, and this wins over a write in the same cycle.
- R6: A counter-zero pulse sets that direction's end-of-block flag only when the mask was 1 before the pulse. With the mask at 0, the pulse leaves the flag at 0.
- R7: An end-of-block flag stays set until its clear input is high. A set in the same cycle as a clear wins. While set, the flag requests its direction's interrupt kind, even with no data flag.
- R8: An acknowledge of the presented request holds off that direction's flag requests until the flag has been seen low. After that, the flag requests again.
- R9: The outputs are registered: they reflect the inputs of the preceding clock edge. During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data_pend | input | 1 | Receive data pending flag |
| tx_buf_empty | input | 1 | Transmit buffer empty flag |
| tx_shift_empty | input | 1 | Transmit shift register empty flag |
| mask_we | input | 1 | Load both DMA masks this cycle |
| rx_mask_wdata | input | 1 | Value loaded into the receive mask |
| tx_mask_wdata | input | 1 | Value loaded into the transmit mask |
| rx_tc_zero | input | 1 | Receive transaction counter reached zero |
| tx_tc_zero | input | 1 | Transmit transaction counter reached zero |
| rx_eob_clr | input | 1 | Software clear of receive end-of-block flag |
| tx_eob_clr | input | 1 | Software clear of transmit end-of-block flag |
| prio_lvl | input | 3 | Port priority level, 7 = none |
| req_ack | input | 1 | Acknowledge of the presented request |
| req_valid | output | 1 | A request is presented |
| req_kind | output | 2 | 0 rx DMA, 1 tx DMA, 2 rx interrupt, 3 tx interrupt |
| req_level | output | 3 | Priority level tagged on the request |
| rx_dma_mask | output | 1 | Current receive DMA mask |
| tx_dma_mask | output | 1 | Current transmit DMA mask |
| rx_eob | output | 1 | Receive end-of-block flag |
| tx_eob | output | 1 | Transmit end-of-block flag |

## Verification
The bench fires a counter-zero pulse in the same cycle as a mask write. A design that lets the write win would leave DMA steering on after the block finished. It fires a counter-zero pulse with the mask already clear, which a careless design would turn into a spurious end-of-block. It also raises a flag set and a flag clear together, where the set must win. The acknowledge cases check that a served flag is not presented again while it is still high, yet returns once the flag drops and rises. Level 7 and the full four-way contention check the gating and the fixed order, since a wrong order would present a lower-priority kind.

// File: rtl/sci_req_pkg.sv
package sci_req_pkg;
    localparam int PRIO_W  = 3;
    localparam int N_DIR   = 2;
    localparam int N_SRC   = 2 * N_DIR;
    localparam int KIND_W  = $clog2(N_SRC);
    localparam logic [PRIO_W-1:0] NO_PRIO = '1;

    typedef enum logic [KIND_W-1:0] {
        K_RX_DMA = 2'd0,
        K_TX_DMA = 2'd1,
        K_RX_INT = 2'd2,
        K_TX_INT = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic [N_DIR-1:0]  mask;
        logic [N_DIR-1:0]  eob;
        logic [N_DIR-1:0]  srv;
        logic              vld;
        req_kind_e         kind;
        logic [PRIO_W-1:0] lvl;
    } ctrl_st_t;
endpackage

// File: rtl/sci_req_steer.sv
module sci_req_steer (
    input  logic flag,
    input  logic mask,
    input  logic served,
    input  logic eob,
    output logic dma_req,
    output logic int_req
);
    logic live;
    assign live    = flag & ~served;
    assign dma_req = live & mask;
    assign int_req = (live & ~mask) | eob;
endmodule

// File: rtl/sci_req_arb.sv
module sci_req_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sci_req_ctrl.sv
module sci_req_ctrl
    import sci_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_data_pend,
    input  logic              tx_buf_empty,
    input  logic              tx_shift_empty,
    input  logic              mask_we,
    input  logic              rx_mask_wdata,
    input  logic              tx_mask_wdata,
    input  logic              rx_tc_zero,
    input  logic              tx_tc_zero,
    input  logic              rx_eob_clr,
    input  logic              tx_eob_clr,
    input  logic [PRIO_W-1:0] prio_lvl,
    input  logic              req_ack,
    output logic              req_valid,
    output logic [KIND_W-1:0] req_kind,
    output logic [PRIO_W-1:0] req_level,
    output logic              rx_dma_mask,
    output logic              tx_dma_mask,
    output logic              rx_eob,
    output logic              tx_eob
);
    ctrl_st_t st_d, st_q;

    logic [N_DIR-1:0] flag, tcz, wdat, clr, ack_dir;
    logic [N_DIR-1:0] mask_n, eob_n, srv_n;
    logic [N_DIR-1:0] dma_req, int_req;
    logic [N_SRC-1:0] src;
    logic             any;
    logic [KIND_W-1:0] win;

    assign flag = {tx_buf_empty | tx_shift_empty, rx_data_pend};
    assign tcz  = {tx_tc_zero, rx_tc_zero};
    assign wdat = {tx_mask_wdata, rx_mask_wdata};
    assign clr  = {tx_eob_clr, rx_eob_clr};

    // direction state: masks, end-of-block flags, served marks
    always_comb begin
        for (int d = 0; d < N_DIR; d++) begin
            ack_dir[d] = req_ack & st_q.vld & (st_q.kind[0] == 1'(d));
            if (tcz[d])       mask_n[d] = 1'b0;
            else if (mask_we) mask_n[d] = wdat[d];
            else              mask_n[d] = st_q.mask[d];
            eob_n[d] = (tcz[d] & st_q.mask[d]) | (st_q.eob[d] & ~clr[d]);
            srv_n[d] = flag[d] & (st_q.srv[d] | ack_dir[d]);
        end
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        sci_req_steer steer_i (
            .flag    (flag[d]),
            .mask    (mask_n[d]),
            .served  (srv_n[d]),
            .eob     (eob_n[d]),
            .dma_req (dma_req[d]),
            .int_req (int_req[d])
        );
    end

    assign src = {int_req, dma_req};

    sci_req_arb #(.N(N_SRC)) arb_i (
        .req (src),
        .any (any),
        .idx (win)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = mask_n;
        st_d.eob  = eob_n;
        st_d.srv  = srv_n;
        st_d.vld  = any & (prio_lvl != NO_PRIO);
        st_d.kind = req_kind_e'(win);
        st_d.lvl  = prio_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_valid   = st_q.vld;
    assign req_kind    = st_q.kind;
    assign req_level   = st_q.lvl;
    assign rx_dma_mask = st_q.mask[0];
    assign tx_dma_mask = st_q.mask[1];
    assign rx_eob      = st_q.eob[0];
    assign tx_eob      = st_q.eob[1];
endmodule

// File: rtl/sci_req_ctrl_chk.sv
module sci_req_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_tc_zero,
    input logic       tx_tc_zero,
    input logic       rx_eob_clr,
    input logic [2:0] prio_lvl,
    input logic       req_ack,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       rx_dma_mask,
    input logic       tx_dma_mask,
    input logic       rx_eob
);
    // R4
    no_prio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_lvl == 3'd7) |=> !req_valid);
    // R5
    rx_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tc_zero |=> !rx_dma_mask);
    // R5
    tx_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tc_zero |=> !tx_dma_mask);
    // R6
    rx_eob_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_tc_zero && rx_dma_mask) |=> rx_eob);
    // R7
    rx_eob_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eob && !rx_eob_clr) |=> rx_eob);
    // R8
    ack_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && req_valid && req_kind == 2'd0) |=> !(req_valid && req_kind == 2'd0));
endmodule

bind sci_req_ctrl sci_req_ctrl_chk chk_i (.*);

// File: tb/sci_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module sci_req_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_data_pend = 0, tx_buf_empty = 0, tx_shift_empty = 0;
    logic mask_we = 0, rx_mask_wdata = 0, tx_mask_wdata = 0;
    logic rx_tc_zero = 0, tx_tc_zero = 0, rx_eob_clr = 0, tx_eob_clr = 0;
    logic [2:0] prio_lvl = 3'd0;
    logic req_ack = 0;
    logic req_valid, rx_dma_mask, tx_dma_mask, rx_eob, tx_eob;
    logic [1:0] req_kind;
    logic [2:0] req_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [1:0] m_mask = 0, m_eob = 0, m_srv = 0;
    logic m_vld = 0;
    logic [1:0] m_kind = 0;
    logic [2:0] m_lvl = 0;

    always #10 clk = ~clk;

    sci_req_ctrl dut_i (.*);

    task automatic model_step();
        logic [1:0] fl, tz, wd, cl, nm, ne, ns, live, dma, irq;
        fl = {tx_buf_empty | tx_shift_empty, rx_data_pend};
        tz = {tx_tc_zero, rx_tc_zero};
        wd = {tx_mask_wdata, rx_mask_wdata};
        cl = {tx_eob_clr, rx_eob_clr};
        for (int d = 0; d < 2; d++) begin
            nm[d] = tz[d] ? 1'b0 : (mask_we ? wd[d] : m_mask[d]);
            ne[d] = (tz[d] & m_mask[d]) | (m_eob[d] & ~cl[d]);
            ns[d] = fl[d] & (m_srv[d] | (req_ack & m_vld & (m_kind[0] == 1'(d))));
        end
        live = fl & ~ns;
        dma  = live & nm;
        irq  = (live & ~nm) | ne;
        if (dma[0])      m_kind = 2'd0;
        else if (dma[1]) m_kind = 2'd1;
        else if (irq[0]) m_kind = 2'd2;
        else if (irq[1]) m_kind = 2'd3;
        m_vld  = (|{dma, irq}) && (prio_lvl != 3'd7);
        m_lvl  = prio_lvl;
        m_mask = nm;
        m_eob  = ne;
        m_srv  = ns;
    endtask

    task automatic check(input string tag);
        checks++;
        if (req_valid !== m_vld || (m_vld && req_kind !== m_kind) ||
            req_level !== m_lvl || {tx_dma_mask, rx_dma_mask} !== m_mask ||
            {tx_eob, rx_eob} !== m_eob) begin
            errors++;
            $display("FAIL %s: got vld=%b kind=%0d lvl=%0d mask=%b eob=%b exp vld=%b kind=%0d lvl=%0d mask=%b eob=%b",
                tag, req_valid, req_kind, req_level, {tx_dma_mask, rx_dma_mask}, {tx_eob, rx_eob},
                m_vld, m_kind, m_lvl, m_mask, m_eob);
        end
    endtask

    task automatic expect_req(input string tag, input logic v, input logic [1:0] k);
        checks++;
        if (req_valid !== v || (v && req_kind !== k)) begin
            errors++;
            $display("FAIL %s: got vld=%b kind=%0d exp vld=%b kind=%0d", tag, req_valid, req_kind, v, k);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset");
        rst_n = 1'b1;
        tick("R9 idle");
        mask_we = 1; rx_mask_wdata = 1; tx_mask_wdata = 0;
        tick("R5 load");
        mask_we = 0; rx_data_pend = 1;
        tick("R1 rx dma"); expect_req("R1 rx dma", 1, 2'd0);
        mask_we = 1; rx_mask_wdata = 0; tx_mask_wdata = 1;
        tick("R1 rx int"); expect_req("R1 rx int", 1, 2'd2);
        mask_we = 0; rx_data_pend = 0; tx_shift_empty = 1;
        tick("R2 tx dma"); expect_req("R2 tx dma", 1, 2'd1);
        tx_shift_empty = 0; tx_buf_empty = 1; rx_data_pend = 1;
        mask_we = 1; rx_mask_wdata = 1; tx_mask_wdata = 1; prio_lvl = 3'd5;
        tick("R3 both dma"); expect_req("R3 both dma", 1, 2'd0);
        mask_we = 0; rx_data_pend = 0;
        tick("R3 tx only"); expect_req("R3 tx only", 1, 2'd1);
        prio_lvl = 3'd7;
        tick("R4 level 7"); expect_req("R4 level 7", 0, 2'd0);
        prio_lvl = 3'd3; tx_buf_empty = 0; rx_tc_zero = 1;
        mask_we = 1; rx_mask_wdata = 1; tx_mask_wdata = 1;
        tick("R5 R6 tc wins"); expect_req("R7 eob int", 1, 2'd2);
        rx_tc_zero = 0; mask_we = 0;
        tick("R7 sticky"); expect_req("R7 sticky", 1, 2'd2);
        tx_tc_zero = 1; rx_eob_clr = 1;
        tick("R6 tx eob"); expect_req("R6 tx eob", 1, 2'd3);
        rx_eob_clr = 0; tx_eob_clr = 1;
        tick("R6 no eob when mask 0"); expect_req("R6 no eob", 0, 2'd0);
        tx_tc_zero = 0; tx_eob_clr = 0; mask_we = 1; rx_mask_wdata = 1; tx_mask_wdata = 0;
        tick("R5 reload");
        mask_we = 0; rx_tc_zero = 1; rx_eob_clr = 1;
        tick("R7 set beats clear"); expect_req("R7 set beats clear", 1, 2'd2);
        rx_tc_zero = 0;
        tick("R7 clear"); expect_req("R7 clear", 0, 2'd0);
        rx_eob_clr = 0; rx_data_pend = 1;
        tick("R8 pre"); expect_req("R8 pre", 1, 2'd2);
        req_ack = 1;
        tick("R8 ack"); expect_req("R8 ack", 0, 2'd0);
        req_ack = 0;
        tick("R8 hold"); expect_req("R8 hold", 0, 2'd0);
        rx_data_pend = 0;
        tick("R8 drop");
        rx_data_pend = 1;
        tick("R8 rearm"); expect_req("R8 rearm", 1, 2'd2);
        for (int i = 0; i < 400; i++) begin
            rx_data_pend   = ($urandom % 3) != 0;
            tx_buf_empty   = ($urandom % 3) == 0;
            tx_shift_empty = ($urandom % 4) == 0;
            mask_we        = ($urandom % 6) == 0;
            rx_mask_wdata  = $urandom % 2;
            tx_mask_wdata  = $urandom % 2;
            rx_tc_zero     = ($urandom % 8) == 0;
            tx_tc_zero     = ($urandom % 8) == 0;
            rx_eob_clr     = ($urandom % 5) == 0;
            tx_eob_clr     = ($urandom % 5) == 0;
            prio_lvl       = 3'($urandom % 8);
            req_ack        = $urandom % 2;
            tick("R3 R9 random");
        end
        done = 1;
        finish_run();
    end
endmodule